// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock generator. The host writes only in block form: after the slave address it sends a command byte and a byte-count byte, both of which are acknowledged and discarded. The data bytes that follow land in the registers one after another, starting at register 0, until the host ends the transfer. The whole register file is presented in parallel on `cfg_o` for the clock logic to use.

Two register pairs, (11,12) and (13,14), must change together. The low byte of a pair is held aside, and both bytes are copied into the live registers only when the high byte arrives in the same transaction. Register 8 sets the readback length. A read returns that length as its first byte and then registers 0 upward. SCL and SDA are sampled with the block clock, which must run well above the bus bit rate. SDA is driven only low, through an enable output.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block answers only to 7-bit address 0x69, which is sent in bits 7:1 of the first byte, with bit 0 set for a read. It acknowledges the address, command, count and data bytes. A transfer to any other address gets no acknowledge and changes no register.
- R2: The command and count bytes have no effect. Data byte k of a write goes to register k, with the first data byte being k = 0.
- R3: A write may stop after any complete byte. Registers reached before the stop hold the new data and all later registers keep their values. A write that stops after the count byte changes nothing.
- R4: Register 8 is the readback length and resets to 0x08. A write of 0x00 to it is ignored and the old value is kept.
- R5: The pairs (11,12) and (13,14) are loaded together only when both bytes of a pair are written in one transaction. If only the low byte is written, neither register of that pair changes.
- R6: After reset all registers read 0x00, except register 8 which reads 0x08, and SDA is released.
- R7: Data bytes beyond register 16 are acknowledged and discarded.
- R8: A read returns the length byte first. Byte j+1 then carries register j when j is below both the length and 17, and 0xFF otherwise. SDA is released after the master does not acknowledge a byte, and again after a stop.
- R9: The SDA drive enable never changes while SCL is high, so the block never creates a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| cfg_o | output | 136 | Register file, register i in bits 8*i+7:8*i |

## Verification
On one clock edge, the arrival of a pair's high byte loads the staged low byte, loads the high byte, and clears the pending flag. Writes that end exactly on the low byte of a pair are compared with writes that run one byte further and with writes that run past the end of the file. After each write every register is compared with a model built from the requirements, so a pair shows either both new bytes or neither. A second case is the master's acknowledge bit: on that bit the block must release SDA and also decide whether to load the next byte. Reads that stop early and reads that run past the readback length check both outcomes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } link_st_e;
endpackage

// File: rtl/smb_cfg_sync.sv
module smb_cfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // sda edge with scl held high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/smb_cfg_link.sv
module smb_cfg_link
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  sda_s_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  byte_t rd_data_i,
  output logic  sda_oe_o,
  output logic  wr_stb_o,
  output byte_t wr_idx_o,
  output byte_t wr_data_o,
  output logic  txn_end_o,
  output byte_t rd_idx_o
);
  link_st_e st_q;
  logic [3:0] bit_cnt_q;
  byte_t sh_q, byte_num_q, rd_idx_q;
  logic is_addr_q, rw_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      byte_num_q <= '0;
      rd_idx_q   <= '0;
      is_addr_q  <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_stb_o   <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
      txn_end_o  <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      txn_end_o <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        is_addr_q <= 1'b1;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
        txn_end_o <= 1'b1;
      end else if (stop_i) begin
        st_q      <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        txn_end_o <= 1'b1;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (is_addr_q) begin
                if (sh_q[7:1] == SLV_ADDR) begin
                  st_q       <= ST_ACK;
                  sda_oe_o   <= 1'b1;
                  rw_q       <= sh_q[0];
                  byte_num_q <= '0;
                  rd_idx_q   <= '0;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                st_q     <= ST_ACK;
                sda_oe_o <= 1'b1;
                // bytes 0,1 are command and count: dropped
                if (byte_num_q >= 8'd2) begin
                  wr_stb_o  <= 1'b1;
                  wr_idx_o  <= byte_num_q - 8'd2;
                  wr_data_o <= sh_q;
                end
                if (byte_num_q != 8'hFF) byte_num_q <= byte_num_q + 8'd1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              is_addr_q <= 1'b0;
              bit_cnt_q <= '0;
              if (is_addr_q && rw_q) begin
                st_q     <= ST_TX;
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                if (rd_idx_q != 8'hFF) rd_idx_q <= rd_idx_q + 8'd1;
              end else begin
                st_q     <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                st_q     <= ST_MACK;
                sda_oe_o <= 1'b0;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (mack_q) begin
                st_q     <= ST_TX;
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                if (rd_idx_q != 8'hFF) rd_idx_q <= rd_idx_q + 8'd1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx_o = rd_idx_q;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int unsigned          NREG    = 17,
  parameter int unsigned          CNT_IDX = 8,
  parameter logic [7:0]           CNT_RST = 8'h08,
  parameter int unsigned          NPAIR   = 2,
  parameter logic [NPAIR*8-1:0]   PAIR_LO = {8'd13, 8'd11}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_stb_i,
  input  byte_t           wr_idx_i,
  input  byte_t           wr_data_i,
  input  logic            txn_end_i,
  output logic [NREG*8-1:0] regs_o
);
  function automatic int pair_lo_of(int idx);
    int r;
    r = -1;
    for (int p = 0; p < int'(NPAIR); p++)
      if (int'(PAIR_LO[p*8 +: 8]) == idx) r = p;
    return r;
  endfunction

  function automatic int pair_hi_of(int idx);
    int r;
    r = -1;
    for (int p = 0; p < int'(NPAIR); p++)
      if (int'(PAIR_LO[p*8 +: 8]) + 1 == idx) r = p;
    return r;
  endfunction

  logic [NPAIR-1:0] pend_q;
  byte_t stage_q [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam byte_t LO = PAIR_LO[p*8 +: 8];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[p]  <= 1'b0;
        stage_q[p] <= '0;
      end else if (txn_end_i) begin
        pend_q[p] <= 1'b0;
      end else if (wr_stb_i && wr_idx_i == LO) begin
        stage_q[p] <= wr_data_i;
        pend_q[p]  <= 1'b1;
      end else if (wr_stb_i && wr_idx_i == LO + 8'd1) begin
        pend_q[p] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int    PL  = pair_lo_of(i);
    localparam int    PH  = pair_hi_of(i);
    localparam byte_t RST = (i == CNT_IDX) ? CNT_RST : 8'h00;
    localparam byte_t IDX = byte_t'(i);
    byte_t q;
    if (i == CNT_IDX) begin : g_cnt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST;
        else if (wr_stb_i && wr_idx_i == IDX && wr_data_i != 8'h00) q <= wr_data_i;
      end
    end else if (PL >= 0) begin : g_lo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST;
        else if (wr_stb_i && wr_idx_i == IDX + 8'd1 && pend_q[PL]) q <= stage_q[PL];
      end
    end else if (PH >= 0) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST;
        else if (wr_stb_i && wr_idx_i == IDX && pend_q[PH]) q <= wr_data_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST;
        else if (wr_stb_i && wr_idx_i == IDX) q <= wr_data_i;
      end
    end
    assign regs_o[i*8 +: 8] = q;
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]         SLV_ADDR    = 7'h69,
  parameter int unsigned        NREG        = 17,
  parameter int unsigned        CNT_IDX     = 8,
  parameter logic [7:0]         CNT_RST     = 8'h08,
  parameter int unsigned        NPAIR       = 2,
  parameter logic [NPAIR*8-1:0] PAIR_LO     = {8'd13, 8'd11},
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_o
);
  logic  scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic  wr_stb, txn_end;
  byte_t wr_idx, wr_data, rd_idx, rd_data, cnt_w;

  smb_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  smb_cfg_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_s_i(sda_s), .start_i(start), .stop_i(stop), .rd_data_i(rd_data),
    .sda_oe_o, .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .txn_end_o(txn_end), .rd_idx_o(rd_idx)
  );

  smb_cfg_regs #(
    .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST),
    .NPAIR(NPAIR), .PAIR_LO(PAIR_LO)
  ) u_regs (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .txn_end_i(txn_end), .regs_o(cfg_o)
  );

  assign cnt_w = cfg_o[CNT_IDX*8 +: 8];

  // read stream: length byte, then registers below the length, else 0xFF
  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx == 8'd0) rd_data = cnt_w;
    else
      for (int i = 0; i < int'(NREG); i++)
        if (rd_idx == byte_t'(i + 1) && byte_t'(i) < cnt_w) rd_data = cfg_o[i*8 +: 8];
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int unsigned        NREG    = 17,
  parameter int unsigned        CNT_IDX = 8,
  parameter int unsigned        NPAIR   = 2,
  parameter logic [NPAIR*8-1:0] PAIR_LO = {8'd13, 8'd11}
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              stop,
  input logic              sda_oe_o,
  input logic              wr_stb,
  input logic [7:0]        wr_idx,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] cfg_o
);
  p_cnt_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[CNT_IDX*8 +: 8] != 8'h00);

  p_cnt_zero_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_idx == 8'(CNT_IDX) && wr_data == 8'h00) |=> $stable(cfg_o[CNT_IDX*8 +: 8]));

  p_past_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_idx >= 8'(NREG)) |=> $stable(cfg_o));

  p_release_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe_o);

  p_oe_scl_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
    localparam int LO = int'(PAIR_LO[p*8 +: 8]);
    // low byte only moves on the edge after its partner is written (R5)
    p_pair_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_o[LO*8 +: 8]) |-> ($past(wr_stb) && $past(wr_idx) == 8'(LO + 1)));
  end
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
  .NREG(NREG), .CNT_IDX(CNT_IDX), .NPAIR(NPAIR), .PAIR_LO(PAIR_LO)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop(stop),
  .sda_oe_o(sda_oe_o), .wr_stb(wr_stb), .wr_idx(wr_idx),
  .wr_data(wr_data), .cfg_o(cfg_o)
);

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
  localparam int NREG = 17;
  localparam int CNT  = 8;
  localparam int Q    = 10;
  localparam logic [6:0] ADDR = 7'h69;
  // {data length, first data value}
  localparam logic [15:0] VEC [8] = '{
    {8'd3,  8'h10}, {8'd12, 8'h20}, {8'd13, 8'h30}, {8'd14, 8'h40},
    {8'd15, 8'h50}, {8'd20, 8'h60}, {8'd9,  8'hF8}, {8'd0,  8'h70}
  };

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1, sda_w;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  logic [7:0] exp_q [NREG];
  int n_chk = 0, n_err = 0, r9_bad = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #5 clk = ~clk;
  assign sda_w = sda_m & ~sda_oe;

  smb_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  // R9 monitor: drive enable must hold while SCL is high
  always @(negedge clk) begin
    if (rst_ni && scl && prev_scl && sda_oe != prev_oe) r9_bad++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    @(negedge clk); b = sda_w;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit last);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(last);
  endtask

  function automatic logic [7:0] dval(input logic [7:0] seed, input int k);
    return seed + 8'(k);
  endfunction

  task automatic wr_txn(input logic [6:0] a, input int len, input logic [7:0] seed, output int acks);
    bit ak;
    acks = 0;
    bus_start();
    send_byte({a, 1'b0}, ak); acks += int'(ak);
    send_byte(8'hA5, ak);     acks += int'(ak);
    send_byte(8'(len), ak);   acks += int'(ak);
    for (int k = 0; k < len; k++) begin send_byte(dval(seed, k), ak); acks += int'(ak); end
    bus_stop();
  endtask

  task automatic model_write(input int len, input logic [7:0] seed);
    for (int k = 0; k < len && k < NREG; k++) begin
      if (k == CNT) begin
        if (dval(seed, k) != 8'h00) exp_q[k] = dval(seed, k);
      end else if (k == 11 || k == 13) begin
        if (k + 1 < len) begin exp_q[k] = dval(seed, k); exp_q[k+1] = dval(seed, k + 1); end
      end else if (k != 12 && k != 14) begin
        exp_q[k] = dval(seed, k);
      end
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg[i*8 +: 8] == exp_q[i], req, cfg[i*8 +: 8], exp_q[i]);
  endtask

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R2";
      1: return "R5";
      2: return "R5";
      3: return "R5";
      4: return "R3";
      5: return "R7";
      6: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic rd_check(input int nbytes);
    bit ak;
    logic [7:0] b, e;
    bus_start();
    send_byte({ADDR, 1'b1}, ak);
    chk(ak, "R1", 8'(ak), 8'h01);
    for (int j = 0; j < nbytes; j++) begin
      recv_byte(b, j == nbytes - 1);
      if (j == 0) e = exp_q[CNT];
      else if (j - 1 < NREG && 8'(j - 1) < exp_q[CNT]) e = exp_q[j-1];
      else e = 8'hFF;
      chk(b == e, "R8", b, e);
    end
    tick(2*Q);
    chk(sda_oe == 1'b0, "R8", 8'(sda_oe), 8'h00);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int acks;
    for (int i = 0; i < NREG; i++) exp_q[i] = (i == CNT) ? 8'h08 : 8'h00;
    tick(5);
    rst_ni = 1'b1;
    tick(5);
    // R6 reset state
    check_regs("R6");
    chk(sda_oe == 1'b0, "R6", 8'(sda_oe), 8'h00);

    // vector table of block writes
    for (int v = 0; v < 8; v++) begin
      int len;
      logic [7:0] seed;
      len  = int'(VEC[v][15:8]);
      seed = VEC[v][7:0];
      wr_txn(ADDR, len, seed, acks);
      model_write(len, seed);
      chk(acks == len + 3, "R1", 8'(acks), 8'(len + 3));
      check_regs(vec_tag(v));
    end

    // R1 foreign address: no acknowledge, no change
    wr_txn(7'h12, 4, 8'hC0, acks);
    chk(acks == 0, "R1", 8'(acks), 8'h00);
    check_regs("R1");

    // readback with full-length stream
    rd_check(NREG + 1);

    // short length: bytes past it read 0xFF (R8)
    wr_txn(ADDR, 9, 8'hFB, acks);
    model_write(9, 8'hFB);
    check_regs("R2");
    rd_check(6);

    chk(r9_bad == 0, "R9", 8'(r9_bad), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule